// File: doc/BRIEF.md
# AAL5 Cell Segmenter

This block turns one packet, presented as a stream of bytes, into a train of 53-byte ATM cells that carry it under AAL5. Packet bytes enter through a byte-wide valid/ready port, and a marker flags the final byte. They are packed in order into a 48-byte cell payload. Once a payload is full, the cell goes out as a 4-byte header, a header check byte and the payload, one byte per clock, with a start-of-cell marker on the first byte.

When the packet ends, the block zero-pads the current payload and closes it with an 8-byte AAL5 trailer. The trailer holds a zero control field, the 16-bit packet length and a CRC-32. If the trailer does not fit after the last data byte, the current cell is padded out and sent, and the trailer gets a cell of its own. The path and channel identifiers come from configuration inputs and are captured when the first byte of a packet is accepted.

Top module: `aal5_segmenter`

## Requirements
- R1: Each cell leaves as 53 consecutive cycles with `out_valid` high. `out_soc` is high only on the first byte of the cell, and the next cycle continues the same cell.
- R2: Packet bytes appear in arrival order from payload offset 0 onward. Cell bytes 5 to 52 are payload offsets 0 to 47. A packet of L bytes yields exactly ceil((L+8)/48) cells. A cell starts in the cycle after its 48th payload byte is accepted.
- R3: The header bytes, first to last, are the 32-bit word {4'h0, vpi[7:0], vci[15:0], 2'b00, eop, 1'b0}, sent most significant byte first.
- R4: The end-of-packet bit (bit 1 of header byte 3) is 1 in the last cell of a packet and 0 in every other cell.
- R5: Cell byte 4 is the CRC-8 of the four header bytes (polynomial x^8+x^2+x+1, zero preset, MSB first), XORed with 0x55.
- R6: Every payload byte between the last data byte and the trailer is zero. If the data ends beyond payload offset 40, the rest of that cell is zeroed and the trailer goes into one more cell, made of zero padding followed by the trailer.
- R7: Payload offsets 40 to 43 of the last cell carry 0x00, 0x00, then the packet length in bytes, high byte first.
- R8: Payload offsets 44 to 47 of the last cell carry the complement of a CRC-32 taken MSB first with polynomial 0x04C11DB7 and an all-ones preset. The CRC covers every payload byte of every cell of the packet, up to and including offset 43 of the last cell. It is stored high byte first.
- R9: `in_ready` is high only while the block is filling a payload with packet data. It is low in every cycle with `out_valid` high and in the cycle after the last byte is accepted.
- R10: While reset is active, and after it is released, `out_valid` and `out_soc` are low and `in_ready` is high. A reset in the middle of a packet discards it, and the next packet is built from a clean state.
- R11: A change to `cfg_vpi` or `cfg_vci` after a packet's first byte has been accepted has no effect on the headers of that packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_vpi | input | 8 | Virtual path identifier for the next packet |
| cfg_vci | input | 16 | Virtual channel identifier for the next packet |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input packet byte |
| in_last | input | 1 | Input byte is the last of the packet |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Output cell byte is valid |
| out_data | output | 8 | Output cell byte |
| out_soc | output | 1 | First byte of a cell |

## Verification
A full payload starts its cell one clock after the 48th byte is accepted. A short final payload first spends one cycle per padding byte, one idle decision cycle, four length cycles and four CRC cycles, and only then starts its cell. `in_ready` falls in the clock after the last byte. Because only the final cell's arrival depends on the padding amount, the bench records every valid output byte at the falling edge together with its start marker. It then checks the stream by cell and offset, not by absolute cycle. The only checks tied to a fixed cycle are the ready level a few cycles after the cells drain, and the outputs while reset is held.

// File: rtl/aal5_segmenter.sv
module aal5_segmenter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg_vpi,
  input  logic [15:0] cfg_vci,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_soc
);
  localparam int PAY_BYTES = 48;
  localparam logic [5:0] LAST_PAY  = 6'd47;
  localparam logic [5:0] FULL_PAY  = 6'd48;
  localparam logic [5:0] TRL_POS   = 6'd40;
  localparam logic [5:0] LEN_LAST  = 6'd43;
  localparam logic [5:0] LAST_CELL = 6'd52;
  localparam logic [5:0] HDR_BYTES = 6'd4;
  localparam logic [5:0] PAY_START = 6'd5;

  typedef enum logic [2:0] {S_FILL, S_PAD, S_LEN, S_CRC, S_SEND} st_t;

  st_t         st;
  logic [7:0]  pay [PAY_BYTES];
  logic [5:0]  pos, cnt, lim;
  logic [31:0] crc, hdr;
  logic [15:0] plen;
  logic [7:0]  vpi_q, wr_byte, hec;
  logic [15:0] vci_q;
  logic        tail, eop, busy, acc, wr_en, upd;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[i]) ? 32'h04C11DB7 : 32'h0);
    return r;
  endfunction

  function automatic logic [7:0] hec_of(input logic [31:0] h);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 31; i >= 0; i--)
      r = {r[6:0], 1'b0} ^ ((r[7] ^ h[i]) ? 8'h07 : 8'h00);
    return r ^ 8'h55;
  endfunction

  assign in_ready  = (st == S_FILL);
  assign acc       = in_valid && in_ready;
  assign out_valid = (st == S_SEND);
  assign out_soc   = out_valid && (cnt == 6'd0);
  assign lim       = eop ? TRL_POS : FULL_PAY;
  assign hdr       = {4'h0, vpi_q, vci_q, 2'b00, eop, 1'b0};
  assign hec       = hec_of(hdr);
  assign upd       = wr_en && (st != S_CRC);

  always_comb begin
    wr_en   = 1'b0;
    wr_byte = 8'h00;
    case (st)
      S_FILL: begin wr_en = acc; wr_byte = in_data; end
      S_PAD:  wr_en = (pos != lim);
      S_LEN: begin
        wr_en = 1'b1;
        case (pos[1:0])
          2'd2:    wr_byte = plen[15:8];
          2'd3:    wr_byte = plen[7:0];
          default: wr_byte = 8'h00;
        endcase
      end
      S_CRC: begin
        wr_en = 1'b1;
        case (pos[1:0])
          2'd0:    wr_byte = ~crc[31:24];
          2'd1:    wr_byte = ~crc[23:16];
          2'd2:    wr_byte = ~crc[15:8];
          default: wr_byte = ~crc[7:0];
        endcase
      end
      default: ;
    endcase
  end

  always_comb begin
    if (cnt < HDR_BYTES) begin
      case (cnt[1:0])
        2'd0:    out_data = hdr[31:24];
        2'd1:    out_data = hdr[23:16];
        2'd2:    out_data = hdr[15:8];
        default: out_data = hdr[7:0];
      endcase
    end else if (cnt == HDR_BYTES) begin
      out_data = hec;
    end else begin
      out_data = pay[cnt - PAY_START];
    end
  end

  always_ff @(posedge clk)
    if (wr_en) pay[pos] <= wr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_FILL;
      pos   <= '0;
      cnt   <= '0;
      crc   <= '1;
      plen  <= '0;
      tail  <= 1'b0;
      eop   <= 1'b0;
      busy  <= 1'b0;
      vpi_q <= '0;
      vci_q <= '0;
    end else begin
      if (upd)   crc <= crc_step(crc, wr_byte);
      if (wr_en) pos <= pos + 6'd1;
      case (st)
        S_FILL: if (acc) begin
          plen <= plen + 16'd1;
          busy <= 1'b1;
          if (!busy) begin
            vpi_q <= cfg_vpi;
            vci_q <= cfg_vci;
          end
          if (in_last) begin
            tail <= 1'b1;
            eop  <= (pos < TRL_POS);
          end
          if (pos == LAST_PAY) st <= S_SEND;
          else if (in_last)    st <= S_PAD;
        end
        S_PAD: if (pos == lim) st <= eop ? S_LEN : S_SEND;
        S_LEN: if (pos == LEN_LAST) st <= S_CRC;
        S_CRC: if (pos == LAST_PAY) st <= S_SEND;
        S_SEND: begin
          cnt <= cnt + 6'd1;
          if (cnt == LAST_CELL) begin
            cnt <= '0;
            pos <= '0;
            if (eop) begin
              st   <= S_FILL;
              tail <= 1'b0;
              eop  <= 1'b0;
              busy <= 1'b0;
              plen <= '0;
              crc  <= '1;
            end else if (tail) begin
              st  <= S_PAD;
              eop <= 1'b1;
            end else begin
              st <= S_FILL;
            end
          end
        end
        default: st <= S_FILL;
      endcase
    end
  end

  assert_soc_in_cell_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> out_valid);
  assert_cell_continues_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |=> (out_valid && !out_soc));
  assert_full_payload_sends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && pos == LAST_PAY) |=> out_soc);
  assert_no_input_while_emit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_stall_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);
  assert_cfg_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(out_valid && cnt == LAST_CELL && eop)) |=> $stable(vpi_q) && $stable(vci_q));
endmodule

// File: tb/aal5_segmenter_tb.sv
`timescale 1ns/1ps
module aal5_segmenter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_vpi = '0, in_data = '0, out_data;
  logic [15:0] cfg_vci = '0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready, out_valid, out_soc;

  aal5_segmenter u_dut (.clk(clk), .rst_n(rst_n), .cfg_vpi(cfg_vpi), .cfg_vci(cfg_vci),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_soc(out_soc));

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0, ncap = 0, viol = 0;
  logic [7:0] cap [0:255];
  logic       scap [0:255];
  logic [7:0] ep [0:191];

  localparam int NV = 10;
  // {length, vpi, vci, expected cells}
  localparam logic [47:0] VECS [NV] = '{
    {16'd1,   8'h01, 16'h0020, 8'd1},
    {16'd39,  8'hA5, 16'h1234, 8'd1},
    {16'd40,  8'h3C, 16'hFFFF, 8'd1},
    {16'd41,  8'hFF, 16'h0001, 8'd2},
    {16'd47,  8'h10, 16'h8000, 8'd2},
    {16'd48,  8'h00, 16'h0100, 8'd2},
    {16'd88,  8'h7E, 16'h5A5A, 8'd2},
    {16'd89,  8'h81, 16'hC3C3, 8'd3},
    {16'd96,  8'h22, 16'h0333, 8'd3},
    {16'd100, 8'h44, 16'h0555, 8'd3}
  };

  always @(negedge clk) begin
    if (out_valid && ncap < 256) begin
      cap[ncap]  = out_data;
      scap[ncap] = out_soc;
      ncap++;
    end
    if (out_valid && in_ready) viol++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input int i, input int seed);
    return 8'((i * 13 + seed) & 255);
  endfunction

  function automatic logic [31:0] crc32_ref(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[31] != d[b]) r = (r << 1) ^ 32'h04C11DB7;
      else               r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] hec_ref(input logic [31:0] h);
    logic [7:0] r;
    r = 8'h00;
    for (int b = 31; b >= 0; b--) begin
      if (r[7] != h[b]) r = (r << 1) ^ 8'h07;
      else              r = r << 1;
    end
    return r ^ 8'h55;
  endfunction

  task automatic send_pkt(input int len, input int seed, input bit gap, input bit chg, input bit term);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (chg && i == 1) begin cfg_vpi = ~cfg_vpi; cfg_vci = ~cfg_vci; end
      in_valid = 1'b1;
      in_data  = dat(i, seed);
      in_last  = term && (i == len - 1);
      while (!in_ready) @(negedge clk);
      if (gap) begin @(negedge clk); in_valid = 1'b0; end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_vec(input int len, input logic [7:0] vpi, input logic [15:0] vci,
                         input int cells, input int seed, input bit gap, input bit chg);
    int n, tot, lim, p, c, o;
    logic [31:0] cr, h;
    logic [7:0] e;
    int bad [7];
    int fa [7];
    int fe [7];
    string tg [7];
    tg = '{"R3", "R4", "R5", "R2", "R6", "R7", "R8"};
    n = 48 * ((len + 8 + 47) / 48);
    for (int k = 0; k < n; k++) ep[k] = (k < len) ? dat(k, seed) : 8'h00;
    ep[n-6] = 8'(len >> 8);
    ep[n-5] = 8'(len & 255);
    cr = 32'hFFFF_FFFF;
    for (int k = 0; k < n - 4; k++) cr = crc32_ref(cr, ep[k]);
    cr = ~cr;
    ep[n-4] = cr[31:24]; ep[n-3] = cr[23:16]; ep[n-2] = cr[15:8]; ep[n-1] = cr[7:0];
    tot = cells * 53;
    cfg_vpi = vpi;
    cfg_vci = vci;
    ncap = 0;
    send_pkt(len, seed, gap, chg, 1'b1);
    for (int t = 0; t < 1000 && ncap < tot; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ncap == tot, "R2", $sformatf("byte count len %0d", len), ncap, tot);
    chk(in_ready == 1'b1 && viol == 0, "R9", "ready after packet / no overlap", {in_ready, 8'(viol)}, 256);
    for (int k = 0; k < 7; k++) begin bad[k] = 0; fa[k] = 0; fe[k] = 0; end
    lim = (ncap < tot) ? ncap : tot;
    begin
      int sb, sa;
      sb = 0; sa = 0;
      for (int j = 0; j < lim; j++)
        if (scap[j] != (j % 53 == 0)) begin if (sb == 0) sa = j; sb++; end
      chk(sb == 0, "R1", $sformatf("start marker len %0d first bad index", len), sa, 0);
    end
    for (int j = 0; j < lim; j++) begin
      int cat;
      c = j / 53;
      o = j % 53;
      h = {4'h0, vpi, vci, 2'b00, (c == cells - 1), 1'b0};
      if (o < 4) begin
        e = h[31 - 8*o -: 8];
        if (o == 3) begin
          if (cap[j][1] != e[1]) begin if (bad[1] == 0) begin fa[1] = cap[j]; fe[1] = e; end bad[1]++; end
          cat = 0;
          if ((cap[j] & 8'hFD) != (e & 8'hFD)) begin if (bad[0] == 0) begin fa[0] = cap[j]; fe[0] = e; end bad[0]++; end
        end else if (cap[j] != e) begin
          if (bad[0] == 0) begin fa[0] = cap[j]; fe[0] = e; end
          bad[0]++;
        end
      end else begin
        if (o == 4) begin
          e = hec_ref(h); cat = 2;
        end else begin
          p = c * 48 + o - 5;
          e = ep[p];
          cat = (p < len) ? 3 : (p < n - 8) ? 4 : (p < n - 4) ? 5 : 6;
        end
        if (cap[j] != e) begin
          if (bad[cat] == 0) begin fa[cat] = cap[j]; fe[cat] = e; end
          bad[cat]++;
        end
      end
    end
    for (int k = 0; k < 7; k++)
      chk(bad[k] == 0, tg[k], $sformatf("cell bytes len %0d", len), fa[k], fe[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R2 watchdog: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs while reset is held
    chk(!out_valid && !out_soc && in_ready, "R10", "outputs in reset", {out_valid, out_soc, in_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_soc && in_ready, "R10", "outputs after reset", {out_valid, out_soc, in_ready}, 3'b001);

    for (int v = 0; v < NV; v++)
      run_vec(int'(VECS[v][47:32]), VECS[v][31:24], VECS[v][23:8], int'(VECS[v][7:0]),
              v * 31 + 5, v[0], 1'b0);

    // R11: configuration changed after the first byte is ignored
    run_vec(100, 8'h5B, 16'h0ABC, 3, 77, 1'b0, 1'b1);

    // R10: reset during cell emission, then a clean packet
    cfg_vpi = 8'h12; cfg_vci = 16'h3456;
    send_pkt(48, 9, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b1, "R2", "cell emitting before mid reset", out_valid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && !out_soc && in_ready, "R10", "outputs on mid-packet reset", {out_valid, out_soc, in_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    viol = 0;
    run_vec(41, 8'h66, 16'h0777, 2, 123, 1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule